// File: doc/BRIEF.md
# I2C Multi-Message Transfer Sequencer

This block runs a list of I2C messages against a byte-level bus master. Each message has a 7-bit target address, a direction and a byte count. The sequencer reads the message descriptors by index and takes write bytes from a stream. It delivers received bytes on an output stream. It issues one bus operation at a time to the byte master (START, repeated START, write byte, read byte, STOP) and waits for each operation to complete before it issues the next.

A transfer opens with a bounded bus-busy pre-check. It sends a START with the first address. A later message gets a repeated START only when its address or its direction differs from the message before it; otherwise its data continues on the same bus phase. On reads, every byte is acknowledged except the last byte of the message. On the final read byte of the whole transfer, STOP is requested before that byte is handed out. A missing acknowledge on an address or write byte, or a completion that never arrives, ends the transfer with STOP. At the end, a one-cycle done pulse carries the number of completed messages and an error code.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A `go` with `n_msgs` = 0 raises `done` on the next cycle with `done_count` = 0 and `err` = 0, and no bus operation is requested.
- R2: Before the first operation, `bus_busy` is sampled up to 5 times, `POLL_GAP` cycles apart. If it is still high at the fifth sample, the transfer ends with `err` = 3, `done_count` = 0 and no operation issued.
- R3: Operation codes on `m_op` are START=0, RSTART=1, WRITE=2, READ=3, STOP=4. The first message uses START. A later message uses RSTART only if its address or direction differs from the previous message; otherwise no address operation is issued. The address byte on `m_wdata` is {address[6:0], read bit}.
- R4: A slave NACK on an address byte issues STOP and ends with `err` = 1. `done_count` is the number of messages completed before the failing one.
- R5: Write bytes are taken from `wr_data` in stream order, one `wr_take` pulse per byte, and each is sent with a WRITE. A NACK on a write byte issues STOP and ends with `err` = 1.
- R6: Each READ carries `m_nack_out` = 0, except the last byte of its message, which carries 1. This includes a single-byte read. On a READ, `m_nack` from the master is ignored.
- R7: The final read byte of a transfer that ends with a read is output with `rd_last` = 1, one cycle after the STOP request. All other read bytes are output with `rd_last` = 0 as soon as they complete.
- R8: If an address or data operation is not completed within 16 × `TRY_CYC` cycles, STOP is issued and the transfer ends with `err` = 2.
- R9: After the last message, STOP is issued. `done` rises once `bus_busy` is seen low at a `POLL_GAP` poll, or after 16 polls. It carries `done_count` = `n_msgs` and `err` = 0.
- R10: `m_req` is a single-cycle pulse. No operation is requested while the block is idle, and none is issued before the previous one has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start a transfer (accepted when idle) |
| n_msgs | input | CNT_W | Number of messages in the transfer |
| msg_idx | output | IDX_W | Index of the descriptor being read |
| msg_addr | input | 7 | Target address of message `msg_idx` |
| msg_rd | input | 1 | Direction of message `msg_idx` (1 = read) |
| msg_len | input | LEN_W | Byte count of message `msg_idx` |
| wr_data | input | 8 | Head of the write byte stream |
| wr_take | output | 1 | Pops the head of the write stream |
| rd_valid | output | 1 | Received byte valid |
| rd_data | output | 8 | Received byte |
| rd_last | output | 1 | Final byte of the transfer |
| m_req | output | 1 | Operation request to the byte master |
| m_op | output | 3 | Operation code |
| m_wdata | output | 8 | Address or data byte to send |
| m_nack_out | output | 1 | Answer this read byte with NACK |
| m_done | input | 1 | Operation complete |
| m_nack | input | 1 | Slave did not acknowledge (sent bytes) |
| m_rdata | input | 8 | Byte received by the master |
| bus_busy | input | 1 | Bus is owned |
| done | output | 1 | Transfer finished (one cycle) |
| done_count | output | CNT_W | Messages completed |
| err | output | 2 | 0 none, 1 NACK, 2 timeout, 3 bus busy |

## Verification
The bound checker watches the port-level rules on every cycle: the one-cycle request pulse, silence while idle, the immediate completion of an empty request, a single START per transfer, the final read byte never appearing before STOP, and a completed count that never exceeds the request. The exact operation order can only be shown by the scenarios, which compare every request against a scoreboard. This covers when a repeated START appears or is skipped, the acknowledge flag on each read byte, and the write byte order. The scenarios also cover the error paths that depend on a modelled slave and bus: NACK on an address byte, NACK on a data byte, a silent master and a bus that stays busy.

// File: rtl/i2c_xfer_pkg.sv
package i2c_xfer_pkg;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_WRITE  = 3'd2,
    OP_READ   = 3'd3,
    OP_STOP   = 3'd4
  } bus_op_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_NACK    = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_BUSY    = 2'd3
  } xfer_err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_MSG, S_ADDR_WAIT, S_DATA, S_DATA_WAIT,
    S_NEXT, S_STOP, S_STOP_POLL
  } seq_state_e;

endpackage

// File: rtl/xfer_try_timer.sv
module xfer_try_timer #(
  parameter int GAP   = 8,
  parameter int TRIES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick,
  output logic final_try
);
  localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam int TW = $clog2(TRIES + 1);

  logic [CW-1:0] cyc;
  logic [TW-1:0] tries;

  assign tick      = run && (cyc == CW'(GAP - 1));
  assign final_try = (tries == TW'(TRIES - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cyc   <= '0;
      tries <= '0;
    end else if (tick) begin
      cyc   <= '0;
      tries <= tries + 1'b1;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end
endmodule

// File: rtl/xfer_addr_cmp.sv
module xfer_addr_cmp
  import i2c_xfer_pkg::*;
(
  input  logic       first,
  input  logic [6:0] prev_addr,
  input  logic       prev_rd,
  input  logic [6:0] addr,
  input  logic       rd,
  output logic       need_addr,
  output bus_op_e    addr_op
);
  always_comb begin
    need_addr = first || (addr != prev_addr) || (rd != prev_rd);
    addr_op   = first ? OP_START : OP_RSTART;
  end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_xfer_pkg::*;
#(
  parameter int MAX_MSGS = 8,
  parameter int LEN_W    = 8,
  parameter int POLL_GAP = 8,
  parameter int TRY_CYC  = 8,
  parameter int PRE_POLLS  = 5,
  parameter int STOP_POLLS = 16,
  parameter int WAIT_TRIES = 16,
  localparam int IDX_W = (MAX_MSGS > 1) ? $clog2(MAX_MSGS) : 1,
  localparam int CNT_W = $clog2(MAX_MSGS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [CNT_W-1:0] n_msgs,
  output logic [IDX_W-1:0] msg_idx,
  input  logic [6:0]       msg_addr,
  input  logic             msg_rd,
  input  logic [LEN_W-1:0] msg_len,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             rd_last,
  output logic             m_req,
  output logic [2:0]       m_op,
  output logic [7:0]       m_wdata,
  output logic             m_nack_out,
  input  logic             m_done,
  input  logic             m_nack,
  input  logic [7:0]       m_rdata,
  input  logic             bus_busy,
  output logic             done,
  output logic [CNT_W-1:0] done_count,
  output logic [1:0]       err
);
  seq_state_e       st;
  bus_op_e          op_q;
  xfer_err_e        err_q;
  logic [IDX_W-1:0] mi;
  logic [CNT_W-1:0] nm, cnt;
  logic [6:0]       prev_addr;
  logic             prev_rd, cur_rd, nack_arm, pend;
  logic [LEN_W-1:0] cur_len, bi;
  logic [7:0]       pend_data;
  logic             need_addr, last_msg;
  bus_op_e          addr_op;
  logic             pre_tick, pre_fin, stp_tick, stp_fin, wt_tick, wt_fin;

  assign msg_idx    = mi;
  assign m_op       = op_q;
  assign err        = err_q;
  assign done_count = cnt;
  assign last_msg   = (CNT_W'(mi) == nm - CNT_W'(1));

  xfer_addr_cmp u_cmp (
    .first(mi == '0), .prev_addr(prev_addr), .prev_rd(prev_rd),
    .addr(msg_addr), .rd(msg_rd), .need_addr(need_addr), .addr_op(addr_op)
  );

  xfer_try_timer #(.GAP(POLL_GAP), .TRIES(PRE_POLLS)) u_pre (
    .clk(clk), .rst(rst), .run(st == S_PRE), .tick(pre_tick), .final_try(pre_fin)
  );
  xfer_try_timer #(.GAP(POLL_GAP), .TRIES(STOP_POLLS)) u_stp (
    .clk(clk), .rst(rst), .run(st == S_STOP_POLL), .tick(stp_tick), .final_try(stp_fin)
  );
  xfer_try_timer #(.GAP(TRY_CYC), .TRIES(WAIT_TRIES)) u_wt (
    .clk(clk), .rst(rst), .run(st == S_ADDR_WAIT || st == S_DATA_WAIT),
    .tick(wt_tick), .final_try(wt_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;      op_q <= OP_START;   err_q <= ERR_NONE;
      mi <= '0;          nm <= '0;           cnt <= '0;
      prev_addr <= '0;   prev_rd <= 1'b0;    cur_rd <= 1'b0;
      cur_len <= '0;     bi <= '0;           nack_arm <= 1'b0;
      pend <= 1'b0;      pend_data <= '0;    done <= 1'b0;
      m_req <= 1'b0;     m_wdata <= '0;      m_nack_out <= 1'b0;
      wr_take <= 1'b0;   rd_valid <= 1'b0;   rd_data <= '0;
      rd_last <= 1'b0;
    end else begin
      m_req    <= 1'b0;
      wr_take  <= 1'b0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      done     <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          cnt   <= '0;
          err_q <= ERR_NONE;
          nm    <= n_msgs;
          mi    <= '0;
          pend  <= 1'b0;
          if (n_msgs == '0) done <= 1'b1;
          else              st   <= S_PRE;
        end
        S_PRE: if (pre_tick) begin
          if (!bus_busy) st <= S_MSG;
          else if (pre_fin) begin
            err_q <= ERR_BUSY;
            done  <= 1'b1;
            st    <= S_IDLE;
          end
        end
        S_MSG: begin
          cur_rd    <= msg_rd;
          cur_len   <= msg_len;
          bi        <= '0;
          nack_arm  <= (msg_len == LEN_W'(1));
          prev_addr <= msg_addr;
          prev_rd   <= msg_rd;
          if (need_addr) begin
            m_req   <= 1'b1;
            op_q    <= addr_op;
            m_wdata <= {msg_addr, msg_rd};
            st      <= S_ADDR_WAIT;
          end else begin
            st <= S_DATA;
          end
        end
        S_ADDR_WAIT: begin
          if (m_done) begin
            if (m_nack) begin err_q <= ERR_NACK; st <= S_STOP; end
            else st <= S_DATA;
          end else if (wt_tick && wt_fin) begin
            err_q <= ERR_TIMEOUT;
            st    <= S_STOP;
          end
        end
        S_DATA: begin
          if (bi == cur_len) st <= S_NEXT;
          else begin
            m_req <= 1'b1;
            st    <= S_DATA_WAIT;
            if (cur_rd) begin
              op_q       <= OP_READ;
              m_nack_out <= nack_arm;
            end else begin
              op_q       <= OP_WRITE;
              m_wdata    <= wr_data;
              m_nack_out <= 1'b0;
              wr_take    <= 1'b1;
            end
          end
        end
        S_DATA_WAIT: begin
          if (m_done) begin
            bi <= bi + 1'b1;
            if (!cur_rd) begin
              if (m_nack) begin err_q <= ERR_NACK; st <= S_STOP; end
              else st <= S_DATA;
            end else begin
              if (bi == cur_len - LEN_W'(2)) nack_arm <= 1'b1;
              if (bi == cur_len - LEN_W'(1) && last_msg) begin
                pend      <= 1'b1;
                pend_data <= m_rdata;
                cnt       <= cnt + 1'b1;
                st        <= S_STOP;
              end else begin
                rd_valid <= 1'b1;
                rd_data  <= m_rdata;
                st       <= S_DATA;
              end
            end
          end else if (wt_tick && wt_fin) begin
            err_q <= ERR_TIMEOUT;
            st    <= S_STOP;
          end
        end
        S_NEXT: begin
          cnt <= cnt + 1'b1;
          if (last_msg) st <= S_STOP;
          else begin
            mi <= mi + 1'b1;
            st <= S_MSG;
          end
        end
        S_STOP: begin
          m_req <= 1'b1;
          op_q  <= OP_STOP;
          st    <= S_STOP_POLL;
        end
        S_STOP_POLL: begin
          if (pend) begin
            rd_valid <= 1'b1;
            rd_last  <= 1'b1;
            rd_data  <= pend_data;
            pend     <= 1'b0;
          end
          if (stp_tick && (!bus_busy || stp_fin)) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk
  import i2c_xfer_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             go,
  input logic [CNT_W-1:0] n_msgs,
  input logic             done,
  input logic [CNT_W-1:0] done_count,
  input logic             m_req,
  input logic [2:0]       m_op,
  input logic             rd_valid,
  input logic             rd_last
);
  logic             act, stop_seen, start_seen, idle_now;
  logic [CNT_W-1:0] n_lat;

  assign idle_now = !act || done;

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0; stop_seen <= 1'b0; start_seen <= 1'b0; n_lat <= '0;
    end else if (go && idle_now) begin
      act        <= (n_msgs != '0);
      n_lat      <= n_msgs;
      stop_seen  <= 1'b0;
      start_seen <= 1'b0;
    end else begin
      if (done) act <= 1'b0;
      if (m_req && m_op == OP_STOP)  stop_seen  <= 1'b1;
      if (m_req && m_op == OP_START) start_seen <= 1'b1;
    end
  end

  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (rst)
    (go && idle_now && n_msgs == '0) |=> (done && done_count == '0 && !m_req)); // R1
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !act |-> !m_req); // R10
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    m_req |=> !m_req); // R10
  AST_SINGLE_START: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_op == OP_START) |-> !start_seen); // R3
  AST_LAST_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_last) |-> stop_seen); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (done && act) |-> (done_count <= n_lat)); // R9
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .go(go), .n_msgs(n_msgs), .done(done),
  .done_count(done_count), .m_req(m_req), .m_op(m_op),
  .rd_valid(rd_valid), .rd_last(rd_last)
);

// File: tb/tb_i2c_xfer_seq.sv
module tb_i2c_xfer_seq;
  localparam int MAXM = 8;
  localparam int CW   = 4;

  logic clk = 1'b0, rst = 1'b1, go = 1'b0;
  logic [CW-1:0] n_msgs = '0;
  logic [2:0] msg_idx;
  logic [6:0] msg_addr;
  logic msg_rd;
  logic [7:0] msg_len, wr_data;
  logic wr_take, rd_valid, rd_last, m_req, m_nack_out, done;
  logic [7:0] rd_data, m_wdata;
  logic [2:0] m_op;
  logic m_done = 1'b0, m_nack = 1'b0;
  logic [7:0] m_rdata = '0;
  logic bus_busy;
  logic [CW-1:0] done_count;
  logic [1:0] err;

  logic [6:0] t_addr [MAXM];
  logic       t_rd   [MAXM];
  logic [7:0] t_len  [MAXM];
  logic [7:0] wbuf   [16];
  int wptr;

  assign msg_addr = t_addr[msg_idx];
  assign msg_rd   = t_rd[msg_idx];
  assign msg_len  = t_len[msg_idx];
  assign wr_data  = wbuf[wptr[3:0]];

  always #2 clk = ~clk;

  i2c_xfer_seq dut (
    .clk(clk), .rst(rst), .go(go), .n_msgs(n_msgs), .msg_idx(msg_idx),
    .msg_addr(msg_addr), .msg_rd(msg_rd), .msg_len(msg_len),
    .wr_data(wr_data), .wr_take(wr_take), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_last(rd_last), .m_req(m_req), .m_op(m_op),
    .m_wdata(m_wdata), .m_nack_out(m_nack_out), .m_done(m_done),
    .m_nack(m_nack), .m_rdata(m_rdata), .bus_busy(bus_busy),
    .done(done), .done_count(done_count), .err(err)
  );

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct { logic [2:0] op; logic [7:0] b; logic nk; string tag; } exp_t;
  exp_t eq[$];
  logic [8:0] rq[$];
  string rtag[$];

  task automatic exp_op(input logic [2:0] op, input logic [7:0] b,
                        input logic nk, input string tag);
    exp_t e;
    e.op = op; e.b = b; e.nk = nk; e.tag = tag;
    eq.push_back(e);
  endtask
  task automatic exp_rd(input logic last, input logic [7:0] d, input string tag);
    rq.push_back({last, d});
    rtag.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (m_req) begin
        if (eq.size() == 0) chk(1'b0, "R10", "unexpected op", int'(m_op), 7);
        else begin
          exp_t e;
          e = eq.pop_front();
          chk(m_op == e.op, e.tag, "op code", int'(m_op), int'(e.op));
          if (e.op <= 3'd2) chk(m_wdata == e.b, e.tag, "sent byte", int'(m_wdata), int'(e.b));
          if (e.op == 3'd3) chk(m_nack_out == e.nk, e.tag, "read nack flag", int'(m_nack_out), int'(e.nk));
        end
      end
      if (rd_valid) begin
        if (rq.size() == 0) chk(1'b0, "R7", "unexpected read byte", int'(rd_data), 0);
        else begin
          logic [8:0] r;
          string t;
          r = rq.pop_front();
          t = rtag.pop_front();
          chk({rd_last, rd_data} == r, t, "read byte/last", int'({rd_last, rd_data}), int'(r));
        end
      end
    end
  end

  // byte master and bus model
  logic model_clr = 1'b0, silent = 1'b0, force_busy = 1'b0, busy_m = 1'b0;
  int nack_at = -1;
  assign bus_busy = busy_m || force_busy;
  int lat = 0, opn = 0, rcnt = 0, stop_cd = 0;
  logic p_read = 1'b0, p_nack = 1'b0;

  always @(negedge clk) begin
    m_done <= 1'b0;
    m_nack <= 1'b0;
    if (model_clr) begin
      lat = 0; opn = 0; rcnt = 0; stop_cd = 0; busy_m <= 1'b0;
    end else begin
      if (lat > 0) begin
        if (lat == 1) begin
          m_done  <= 1'b1;
          m_nack  <= p_nack;
          m_rdata <= 8'h30 + 8'(rcnt);
          if (p_read) rcnt++;
        end
        lat--;
      end
      if (stop_cd > 0) begin
        if (stop_cd == 1) busy_m <= 1'b0;
        stop_cd--;
      end
      if (m_req && m_op != 3'd4) begin
        p_nack = (opn == nack_at);
        p_read = (m_op == 3'd3);
        opn++;
        if (!silent) lat = 3;
        if (m_op == 3'd0) busy_m <= 1'b1;
      end
      if (m_req && m_op == 3'd4) stop_cd = 3;
    end
  end
  always @(posedge wr_take) wptr++;

  task automatic setup();
    @(negedge clk);
    model_clr = 1'b1;
    @(negedge clk);
    model_clr = 1'b0;
    wptr = 0;
    for (int i = 0; i < 16; i++) wbuf[i] = 8'hC0 + 8'(i);
  endtask

  task automatic run(input int n, input int exp_cnt, input int exp_err,
                     input string tag);
    int k;
    @(negedge clk);
    n_msgs = CW'(n);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    k = 0;
    while (!done && k < 5000) begin @(negedge clk); k++; end
    chk(done, tag, "done seen", int'(done), 1);
    chk(done_count == CW'(exp_cnt), tag, "done_count", int'(done_count), exp_cnt);
    chk(err == 2'(exp_err), tag, "err", int'(err), exp_err);
    if (n == 0) chk(k == 0, "R1", "done latency", k, 0);
    repeat (2) @(negedge clk);
    chk(eq.size() == 0, tag, "ops left over", eq.size(), 0);
    chk(rq.size() == 0, tag, "read bytes left over", rq.size(), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(!done && !m_req && !rd_valid && !wr_take, "R10", "reset outputs",
        int'({done, m_req, rd_valid, wr_take}), 0);
    rst = 1'b0;

    // R1: empty request
    setup();
    run(0, 0, 0, "R1");

    // R3 R5 R6 R7 R9: write 2 -> read 3 (dir change) -> read 1 (same, continues)
    setup();
    t_addr[0] = 7'h50; t_rd[0] = 1'b0; t_len[0] = 8'd2;
    t_addr[1] = 7'h50; t_rd[1] = 1'b1; t_len[1] = 8'd3;
    t_addr[2] = 7'h50; t_rd[2] = 1'b1; t_len[2] = 8'd1;
    exp_op(3'd0, 8'hA0, 1'b0, "R3");
    exp_op(3'd2, 8'hC0, 1'b0, "R5");
    exp_op(3'd2, 8'hC1, 1'b0, "R5");
    exp_op(3'd1, 8'hA1, 1'b0, "R3");
    exp_op(3'd3, 8'h00, 1'b0, "R6");
    exp_op(3'd3, 8'h00, 1'b0, "R6");
    exp_op(3'd3, 8'h00, 1'b1, "R6");
    exp_op(3'd3, 8'h00, 1'b1, "R6");
    exp_op(3'd4, 8'h00, 1'b0, "R9");
    exp_rd(1'b0, 8'h30, "R7");
    exp_rd(1'b0, 8'h31, "R7");
    exp_rd(1'b0, 8'h32, "R7");
    exp_rd(1'b1, 8'h33, "R7");
    run(3, 3, 0, "R9");

    // R3: address change gives repeated START
    setup();
    t_addr[0] = 7'h20; t_rd[0] = 1'b0; t_len[0] = 8'd1;
    t_addr[1] = 7'h21; t_rd[1] = 1'b0; t_len[1] = 8'd2;
    exp_op(3'd0, 8'h40, 1'b0, "R3");
    exp_op(3'd2, 8'hC0, 1'b0, "R5");
    exp_op(3'd1, 8'h42, 1'b0, "R3");
    exp_op(3'd2, 8'hC1, 1'b0, "R5");
    exp_op(3'd2, 8'hC2, 1'b0, "R5");
    exp_op(3'd4, 8'h00, 1'b0, "R9");
    run(2, 2, 0, "R9");

    // R3: same address and direction continues without address phase
    setup();
    t_addr[0] = 7'h20; t_rd[0] = 1'b0; t_len[0] = 8'd1;
    t_addr[1] = 7'h20; t_rd[1] = 1'b0; t_len[1] = 8'd1;
    exp_op(3'd0, 8'h40, 1'b0, "R3");
    exp_op(3'd2, 8'hC0, 1'b0, "R3");
    exp_op(3'd2, 8'hC1, 1'b0, "R3");
    exp_op(3'd4, 8'h00, 1'b0, "R9");
    run(2, 2, 0, "R3");

    // R4: NACK on repeated START address
    setup();
    nack_at = 2;
    t_addr[0] = 7'h10; t_rd[0] = 1'b0; t_len[0] = 8'd1;
    t_addr[1] = 7'h12; t_rd[1] = 1'b0; t_len[1] = 8'd1;
    exp_op(3'd0, 8'h20, 1'b0, "R4");
    exp_op(3'd2, 8'hC0, 1'b0, "R4");
    exp_op(3'd1, 8'h24, 1'b0, "R4");
    exp_op(3'd4, 8'h00, 1'b0, "R4");
    run(2, 1, 1, "R4");

    // R5: NACK on second data byte
    setup();
    nack_at = 2;
    t_addr[0] = 7'h33; t_rd[0] = 1'b0; t_len[0] = 8'd3;
    exp_op(3'd0, 8'h66, 1'b0, "R5");
    exp_op(3'd2, 8'hC0, 1'b0, "R5");
    exp_op(3'd2, 8'hC1, 1'b0, "R5");
    exp_op(3'd4, 8'h00, 1'b0, "R5");
    run(1, 0, 1, "R5");
    nack_at = -1;

    // R6: read ignores master NACK input; single-byte read flagged early
    setup();
    nack_at = 1;
    t_addr[0] = 7'h08; t_rd[0] = 1'b1; t_len[0] = 8'd1;
    t_addr[1] = 7'h09; t_rd[1] = 1'b0; t_len[1] = 8'd1;
    exp_op(3'd0, 8'h11, 1'b0, "R6");
    exp_op(3'd3, 8'h00, 1'b1, "R6");
    exp_op(3'd1, 8'h12, 1'b0, "R6");
    exp_op(3'd2, 8'hC0, 1'b0, "R6");
    exp_op(3'd4, 8'h00, 1'b0, "R6");
    exp_rd(1'b0, 8'h30, "R6");
    run(2, 2, 0, "R6");
    nack_at = -1;

    // R8: master never completes
    setup();
    silent = 1'b1;
    t_addr[0] = 7'h44; t_rd[0] = 1'b0; t_len[0] = 8'd1;
    exp_op(3'd0, 8'h88, 1'b0, "R8");
    exp_op(3'd4, 8'h00, 1'b0, "R8");
    run(1, 0, 2, "R8");
    silent = 1'b0;

    // R2: bus stays busy through every pre-check poll
    setup();
    force_busy = 1'b1;
    run(1, 0, 3, "R2");
    force_busy = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule